// File: doc/BRIEF.md
# Framed Serial/Parallel Word Converter

This block converts one W-bit word at a time (W = 4 by default) between a parallel bus and a single serial line. The direction is picked per word: in transmit mode a parallel word goes out on the serial line, and in receive mode serial bits are gathered into a parallel word. Every word runs the same fixed frame of W+2 cycles. The frame starts with a cycle that zeroes all stages. Next comes either a parallel load followed by shifting (transmit) or W capture cycles (receive). The frame ends with a cycle after which the stages are zeroed again. Nothing shifts outside a frame.

A one-cycle `start` strobe in the idle state begins a frame, and `mode` is sampled in the same cycle. `busy` covers the whole frame. An internal bit counter ends the frame, so the user never counts shifts. In receive mode `word_valid` marks the one cycle in which `par_out` holds the complete word. There is no back-pressure: the consumer must take the word in that cycle, and the producer must hold off while `busy` is high, because a strobe arriving then is dropped. The bit order on the line is most significant bit first in both directions.

Top module: `word_serdes4`

## Requirements
- R1: While `clr` is high at a rising edge, the block returns to idle. In the following cycle `busy`, `word_valid`, `ser_out` and every bit of `par_out` are 0, even if a frame was in progress.
- R2: `start` = 1 in an idle cycle begins a frame, and `mode` is sampled at the same edge (1 = transmit, 0 = receive). `busy` is then high for exactly W+2 cycles, numbered 1 to W+2, starting in the next cycle. A start in the first idle cycle after a frame begins the next frame at once.
- R3: `start` and `mode` are ignored while `busy` is high. The frame keeps its length and its direction.
- R4: Frame cycle 1 zeroes the stages, so `par_out` is 0 in frame cycle 2.
- R5: In transmit mode, `par_in` is sampled at the end of frame cycle 2. Frame cycles 3 to W+2 carry the word on `ser_out`, most significant bit first. For example, 0101 gives 0, 1, 0, 1.
- R6: `ser_out` is 0 in every cycle other than the transmit bit cycles. This covers idle, frame cycles 1 and 2, and the whole of a receive frame.
- R7: In receive mode, `ser_in` is sampled at the end of frame cycles 2 to W+1. Each new bit enters `par_out[0]` and earlier bits move one place toward bit W-1. In frame cycle W+2 the first received bit sits in `par_out[W-1]`.
- R8: `word_valid` is high in frame cycle W+2 of a receive frame only. That is exactly one cycle per received word, and it is never high in transmit mode.
- R9: In transmit frame cycle k (3 to W+2), `par_out` equals the loaded word shifted left by k-3 places, with zeros filled in.
- R10: The edge that ends frame cycle W+2 zeroes the stages, so `par_out` is 0 in the idle cycle after a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high |
| start | input | 1 | Begins a frame when idle |
| mode | input | 1 | 1 = transmit, 0 = receive, sampled with start |
| par_in | input | W | Word to transmit, sampled at the end of frame cycle 2 |
| ser_in | input | 1 | Serial receive line |
| par_out | output | W | Current stage contents |
| ser_out | output | 1 | Serial transmit line, low when not sending |
| busy | output | 1 | High for the W+2 cycles of a frame |
| word_valid | output | 1 | One-cycle mark of a complete received word |

## Verification
The bench pulses `start` in the middle of a frame with the opposite mode. A design that re-arms on that strobe would stretch the frame or flip its direction, and the serial word or the `busy` length would come out wrong. Frames are run back to back with no idle gap between them. Here an off-by-one in the bit counter would drop or repeat the last bit, and a missing end-of-frame clear would leak a stale word into the next frame. A `clr` is applied in the middle of a frame to show that the frame is abandoned at once. The pattern 0101 and a sweep of pseudo-random words in both directions catch a reversed bit order, which would show up as a mirrored word on `ser_out` or `par_out`.

// File: rtl/wsd_pkg.sv
package wsd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOAD,
    ST_SHIFT,
    ST_POST
  } wsd_state_e;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_CLEAR,
    OP_LOAD,
    OP_SHIFT
  } wsd_op_e;
endpackage

// File: rtl/wsd_sequencer.sv
module wsd_sequencer
  import wsd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic    clk,
  input  logic    clr,
  input  logic    start,
  input  logic    mode,
  output wsd_op_e op,
  output logic    tx_mode,
  output logic    busy,
  output logic    word_valid,
  output logic    line_en
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] TX_LAST = CW'(W - 2);
  localparam logic [CW-1:0] RX_LAST = CW'(W - 1);

  wsd_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic tx_q, tx_d;
  logic last_bit;

  assign last_bit = tx_q ? (cnt_q == TX_LAST) : (cnt_q == RX_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tx_d    = tx_q;
    op      = OP_HOLD;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_PRE;
          tx_d    = mode;
        end
      end
      ST_PRE: begin
        op      = OP_CLEAR;
        cnt_d   = '0;
        state_d = tx_q ? ST_LOAD : ST_SHIFT;
      end
      ST_LOAD: begin
        op      = OP_LOAD;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        op = OP_SHIFT;
        if (last_bit) state_d = ST_POST;
        else          cnt_d   = cnt_q + 1'b1;
      end
      ST_POST: begin
        op      = OP_CLEAR;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tx_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
    end
  end

  assign tx_mode    = tx_q;
  assign busy       = (state_q != ST_IDLE);
  assign word_valid = !tx_q && (state_q == ST_POST);
  assign line_en    = tx_q && ((state_q == ST_SHIFT) || (state_q == ST_POST));
endmodule

// File: rtl/wsd_stages.sv
module wsd_stages
  import wsd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  wsd_op_e      op,
  input  logic         fill,
  input  logic [W-1:0] load_word,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic from_prev;
    if (i == 0) begin : g_head
      assign from_prev = fill;
    end else begin : g_body
      assign from_prev = q[i-1];
    end

    always_comb begin
      unique case (op)
        OP_CLEAR: nxt[i] = 1'b0;
        OP_LOAD:  nxt[i] = load_word[i];
        OP_SHIFT: nxt[i] = from_prev;
        default:  nxt[i] = q[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/word_serdes4.sv
module word_serdes4
  import wsd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         start,
  input  logic         mode,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] par_out,
  output logic         ser_out,
  output logic         busy,
  output logic         word_valid
);
  wsd_op_e op;
  logic tx_mode, line_en;
  logic [W-1:0] stg;

  wsd_sequencer #(.W(W)) u_seq (
    .clk        (clk),
    .clr        (clr),
    .start      (start),
    .mode       (mode),
    .op         (op),
    .tx_mode    (tx_mode),
    .busy       (busy),
    .word_valid (word_valid),
    .line_en    (line_en)
  );

  wsd_stages #(.W(W)) u_stg (
    .clk       (clk),
    .clr       (clr),
    .op        (op),
    .fill      (ser_in & ~tx_mode),
    .load_word (par_in),
    .q         (stg)
  );

  assign par_out = stg;
  assign ser_out = line_en & stg[W-1];
endmodule

// File: rtl/wsd_checker.sv
module wsd_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr,
  input logic         start,
  input logic         busy,
  input logic         word_valid,
  input logic         ser_out,
  input logic [W-1:0] par_out
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> (!busy && !word_valid && !ser_out && par_out == '0));

  assert_start_R2: assert property (@(posedge clk) disable iff (clr)
    $rose(busy) |-> $past(start));

  assert_preclear_R4: assert property (@(posedge clk) disable iff (clr)
    $rose(busy) |=> (par_out == '0));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (clr)
    !busy |-> !ser_out);

  assert_inframe_R8: assert property (@(posedge clk) disable iff (clr)
    word_valid |-> busy);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (clr)
    word_valid |=> !word_valid);

  assert_postclear_R10: assert property (@(posedge clk) disable iff (clr)
    $fell(busy) |-> (par_out == '0));
endmodule

bind word_serdes4 wsd_checker #(.W(W)) u_wsd_chk (
  .clk        (clk),
  .clr        (clr),
  .start      (start),
  .busy       (busy),
  .word_valid (word_valid),
  .ser_out    (ser_out),
  .par_out    (par_out)
);

// File: tb/test_word_serdes4.sv
`timescale 1ns/1ps
module test_word_serdes4;
  localparam int W = 4;

  logic clk = 1'b0, clr = 1'b1, start = 1'b0, mode = 1'b0, ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] par_out;
  logic ser_out, busy, word_valid;

  int n_cmp = 0, n_bad = 0, busy_cnt = 0;
  bit done = 0, armed = 0;
  int m_pos = 0;
  bit m_tx = 0;
  logic [W-1:0] m_stg = '0, rx_word = '0, got_word = '0;
  logic bitq[$];
  logic [W-1:0] lfsr = 4'b1001;

  always #2.5 clk = ~clk;

  word_serdes4 #(.W(W)) i_word_serdes4 (
    .clk(clk), .clr(clr), .start(start), .mode(mode), .par_in(par_in),
    .ser_in(ser_in), .par_out(par_out), .ser_out(ser_out), .busy(busy),
    .word_valid(word_valid)
  );

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: frame position counter
  always @(posedge clk) begin
    if (clr) begin
      m_pos = 0; m_stg = '0; m_tx = 0; armed = 1;
    end else if (m_pos == 0) begin
      if (start) begin m_pos = 1; m_tx = mode; end
    end else begin
      if (m_pos == 1 || m_pos == W + 2) m_stg = '0;
      else if (m_tx && m_pos == 2)     m_stg = par_in;
      else if (m_tx)                   m_stg = m_stg << 1;
      else                             m_stg = {m_stg[W-2:0], ser_in};
      m_pos = (m_pos == W + 2) ? 0 : m_pos + 1;
    end
  end

  always @(negedge clk) begin
    bit bitcyc;
    if (armed && !clr) begin
      bitcyc = m_tx && (m_pos >= 3);
      check("R2 busy", int'(busy), int'(m_pos != 0));
      check(bitcyc ? "R5 ser_out" : "R6 ser_out", int'(ser_out),
            bitcyc ? int'(m_stg[W-1]) : 0);
      check("R8 word_valid", int'(word_valid), int'(!m_tx && m_pos == W + 2));
      check(m_pos == 0 ? "R10 par_out" : (m_pos <= 2 ? "R4 par_out" :
            (m_tx ? "R9 par_out" : "R7 par_out")), int'(par_out), int'(m_stg));
      if (bitcyc) bitq.push_back(ser_out);
      if (busy) busy_cnt++;
      if (word_valid) got_word = par_out;
      ser_in = (!m_tx && m_pos >= 2 && m_pos <= W + 1) ? rx_word[W-1-(m_pos-2)] : 1'b0;
    end
  end

  task automatic verify_frame(bit m, logic [W-1:0] w, string tag);
    int v = 0;
    if (m) begin
      foreach (bitq[i]) v = (v << 1) | int'(bitq[i]);
      check({tag, " serial count"}, bitq.size(), W);
      check({tag, " serial word"}, v, int'(w));
    end else begin
      check({tag, " received word"}, int'(got_word), int'(w));
    end
    check({tag, " frame length"}, busy_cnt, W + 2);
  endtask

  task automatic run_frame(bit m, logic [W-1:0] w, string tag);
    bitq.delete(); busy_cnt = 0; got_word = '0;
    start = 1'b1; mode = m; par_in = w; rx_word = w;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 2) @(negedge clk);
    verify_frame(m, w, tag);
  endtask

  task automatic check_zero(string tag);
    check({tag, " busy"}, int'(busy), 0);
    check({tag, " word_valid"}, int'(word_valid), 0);
    check({tag, " ser_out"}, int'(ser_out), 0);
    check({tag, " par_out"}, int'(par_out), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    clr = 1'b0;
    check_zero("R1 reset");
    @(negedge clk);

    run_frame(1'b1, 4'b0101, "R5");
    run_frame(1'b0, 4'b1011, "R7");

    // R3: strobe with flipped mode during a transmit frame
    bitq.delete(); busy_cnt = 0;
    start = 1'b1; mode = 1'b1; par_in = 4'b1100; rx_word = 4'b0011;
    @(negedge clk);
    mode = 1'b0;
    repeat (W) @(negedge clk);
    start = 1'b0; par_in = 4'b0110;
    repeat (2) @(negedge clk);
    verify_frame(1'b1, 4'b1100, "R3");

    // back-to-back frames in both directions
    for (int k = 0; k < 12; k++) begin
      lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      run_frame(k[0], lfsr, k[0] ? "R5 sweep" : "R7 sweep");
    end
    run_frame(1'b0, 4'b1000, "R7 edge");
    run_frame(1'b1, 4'b1111, "R5 edge");

    // R1: clear in the middle of a frame
    start = 1'b1; mode = 1'b1; par_in = 4'b1111;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check_zero("R1 mid-frame");
    repeat (2) @(negedge clk);
    run_frame(1'b0, 4'b0110, "R7 after clear");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule